// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides, once per clock, whether the processor core enters an exception, and which one. It takes four request sources: a software trap, an undefined-instruction trap, a fast interrupt, and a normal interrupt. The normal interrupt is formed inside the block from the peripheral enable, flag and master-enable words. When an entry is taken, the block owns the processor status word. It switches the mode field, sets the mask bits, and hands the pre-entry status to the register file as the saved copy for the new mode. It also supplies the link value, the next-fetch address at the vector, and the program-counter value one word beyond the vector.

All results are registered. They appear one clock after the requesting cycle, together with a single-cycle entry strobe and a cause code. Outside entry, the core may overwrite the status word through a write port, for example to clear the mask bits.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the status output is 0x0000_005F (mode 0x1F, interrupt mask bit 7 clear, fast-interrupt mask bit 6 set). The entry strobe, cause, link, saved-status, next-fetch and PC outputs are all zero.
- R2: A software trap, when taken, gives cause code 0, mode 0x13, next-fetch 0x08, and link equal to the sampled PC minus 4.
- R3: An undefined-instruction trap, when taken, gives cause code 1, mode 0x1B, next-fetch 0x04, and link equal to the sampled PC minus 4.
- R4: A normal interrupt, when taken, gives cause code 2, mode 0x12, next-fetch 0x18, and link equal to the sampled PC unchanged.
- R5: A fast interrupt, when taken, gives cause code 3, mode 0x11, next-fetch 0x1C, and link equal to the sampled PC. It also sets status bit 6.
- R6: Every entry sets status bit 7 and leaves status bits 31:8 and bit 5 unchanged. The saved-status output carries the status word as it stood before the entry.
- R7: A normal interrupt is taken only when status bit 7 is clear, the bitwise AND of enable and flag is nonzero, and bit 0 of the master-enable word is set.
- R8: A fast-interrupt request has no effect while status bit 6 is set.
- R9: When several sources are eligible in the same cycle, only one is entered, in the order fast interrupt, normal interrupt, undefined, software trap.
- R10: After an entry, the PC output equals the next-fetch address plus 4.
- R11: The entry strobe is high for exactly the one cycle following each accepted request. Link, saved-status, next-fetch and PC hold their values until the next entry.
- R12: A status write loads the write data one clock later when no entry is taken in that cycle. When an entry is taken in the same cycle, the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swi_req | input | 1 | Software trap request |
| und_req | input | 1 | Undefined-instruction trap request |
| fiq_req | input | 1 | Fast interrupt request |
| int_enable | input | IRQ_LINES | Peripheral interrupt enable word |
| int_flag | input | IRQ_LINES | Peripheral interrupt flag word |
| int_master | input | IRQ_LINES | Master-enable word (bit 0 used) |
| cur_pc | input | 32 | Current program counter |
| status_wr | input | 1 | Status write strobe |
| status_wdata | input | 32 | Status write data |
| status_o | output | 32 | Current status word |
| entry_pulse | output | 1 | One-cycle entry strobe |
| entry_cause | output | 2 | Cause code of the last entry |
| link_o | output | 32 | Link register value for the new mode |
| spsr_o | output | 32 | Saved status for the new mode |
| next_fetch | output | 32 | Fetch address (vector) |
| pc_next | output | 32 | PC register value (vector + 4) |

## Verification
The hardest condition to reach from the ports is an entry that coincides with a status write, or with a source that the previous entry has just masked. Reaching it takes a status word with both mask bits open while several requests are held. The bench first opens the masks through the write port. It then raises requests in overlapping combinations, so that each entry closes the mask for the next cycle's interrupt. Finally it issues a write in the same cycle as a trap, to show that the write is dropped.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int XLEN = 32;
  localparam int IMASK_BIT = 7;
  localparam int FMASK_BIT = 6;
  localparam int MODE_W = 5;
  localparam logic [XLEN-1:0] STATUS_RESET = 32'h0000_005F;

  typedef enum logic [1:0] {
    CAUSE_SWI = 2'd0,
    CAUSE_UND = 2'd1,
    CAUSE_IRQ = 2'd2,
    CAUSE_FIQ = 2'd3
  } cause_e;

  function automatic logic [MODE_W-1:0] mode_for(cause_e c);
    case (c)
      CAUSE_SWI: return 5'h13;
      CAUSE_UND: return 5'h1B;
      CAUSE_IRQ: return 5'h12;
      default:   return 5'h11;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] vector_for(cause_e c);
    case (c)
      CAUSE_SWI: return 32'h08;
      CAUSE_UND: return 32'h04;
      CAUSE_IRQ: return 32'h18;
      default:   return 32'h1C;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] link_for(cause_e c, logic [XLEN-1:0] pc);
    if (c == CAUSE_SWI || c == CAUSE_UND) return pc - 32'd4;
    return pc;
  endfunction

  function automatic logic [XLEN-1:0] status_after(cause_e c, logic [XLEN-1:0] s);
    logic [XLEN-1:0] r;
    r = s;
    r[MODE_W-1:0] = mode_for(c);
    r[IMASK_BIT] = 1'b1;
    if (c == CAUSE_FIQ) r[FMASK_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
  parameter int IRQ_LINES = 16
) (
  input  logic [IRQ_LINES-1:0] int_enable,
  input  logic [IRQ_LINES-1:0] int_flag,
  input  logic [IRQ_LINES-1:0] int_master,
  input  logic                 imask,
  input  logic                 fmask,
  input  logic                 fiq_req,
  output logic                 irq_live,
  output logic                 fiq_live
);
  logic [IRQ_LINES-1:0] match;
  always_comb begin
    match    = int_enable & int_flag;
    irq_live = !imask && (|match) && int_master[0];
    fiq_live = fiq_req && !fmask;
  end
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_seq_pkg::*;
(
  input  logic   fiq_live,
  input  logic   irq_live,
  input  logic   und_req,
  input  logic   swi_req,
  output logic   take,
  output cause_e cause
);
  always_comb begin
    take  = fiq_live | irq_live | und_req | swi_req;
    if (fiq_live)      cause = CAUSE_FIQ;
    else if (irq_live) cause = CAUSE_IRQ;
    else if (und_req)  cause = CAUSE_UND;
    else               cause = CAUSE_SWI;
  end
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  cause_e          cause,
  input  logic            wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    status_q <= STATUS_RESET;
    else if (take) status_q <= status_after(cause, status_q);
    else if (wr)   status_q <= wdata;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int IRQ_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 swi_req,
  input  logic                 und_req,
  input  logic                 fiq_req,
  input  logic [IRQ_LINES-1:0] int_enable,
  input  logic [IRQ_LINES-1:0] int_flag,
  input  logic [IRQ_LINES-1:0] int_master,
  input  logic [31:0]          cur_pc,
  input  logic                 status_wr,
  input  logic [31:0]          status_wdata,
  output logic [31:0]          status_o,
  output logic                 entry_pulse,
  output logic [1:0]           entry_cause,
  output logic [31:0]          link_o,
  output logic [31:0]          spsr_o,
  output logic [31:0]          next_fetch,
  output logic [31:0]          pc_next
);
  logic   irq_live;
  logic   fiq_live;
  logic   take;
  cause_e cause;

  exc_irq_gate #(.IRQ_LINES(IRQ_LINES)) u_gate (
    .int_enable(int_enable), .int_flag(int_flag), .int_master(int_master),
    .imask(status_o[IMASK_BIT]), .fmask(status_o[FMASK_BIT]),
    .fiq_req(fiq_req), .irq_live(irq_live), .fiq_live(fiq_live)
  );

  exc_prio_arb u_arb (
    .fiq_live(fiq_live), .irq_live(irq_live), .und_req(und_req),
    .swi_req(swi_req), .take(take), .cause(cause)
  );

  exc_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .take(take), .cause(cause),
    .wr(status_wr), .wdata(status_wdata), .status_q(status_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_pulse <= 1'b0;
      entry_cause <= 2'd0;
      link_o      <= '0;
      spsr_o      <= '0;
      next_fetch  <= '0;
      pc_next     <= '0;
    end else begin
      entry_pulse <= take;
      if (take) begin
        entry_cause <= cause;
        link_o      <= link_for(cause, cur_pc);
        spsr_o      <= status_o;
        next_fetch  <= vector_for(cause);
        pc_next     <= vector_for(cause) + 32'd4;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int IRQ_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 swi_req,
  input logic                 und_req,
  input logic                 fiq_req,
  input logic [IRQ_LINES-1:0] int_enable,
  input logic [IRQ_LINES-1:0] int_flag,
  input logic [IRQ_LINES-1:0] int_master,
  input logic                 status_wr,
  input logic [31:0]          status_wdata,
  input logic [31:0]          status_o,
  input logic                 entry_pulse,
  input logic [1:0]           entry_cause,
  input logic [31:0]          spsr_o,
  input logic [31:0]          next_fetch,
  input logic [31:0]          pc_next
);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_pulse && entry_cause == 2'd2) |->
      $past(!status_o[7] && (|(int_enable & int_flag)) && int_master[0]));
  // R8
  fiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_pulse && entry_cause == 2'd3) |-> $past(fiq_req && !status_o[6]));
  // R5
  fiq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_pulse && entry_cause == 2'd3) |-> (status_o[6] && status_o[4:0] == 5'h11));
  // R6
  saved_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_pulse |-> (status_o[7] && spsr_o == $past(status_o)));
  // R10
  pc_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_pulse |-> (pc_next == next_fetch + 32'd4));
  // R9
  swi_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_pulse && entry_cause == 2'd0) |-> $past(!und_req && !(fiq_req && !status_o[6])));
  // R12
  status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_wr) && !entry_pulse) |-> status_o == $past(status_wdata));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.IRQ_LINES(IRQ_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .swi_req(swi_req), .und_req(und_req),
  .fiq_req(fiq_req), .int_enable(int_enable), .int_flag(int_flag),
  .int_master(int_master), .status_wr(status_wr), .status_wdata(status_wdata),
  .status_o(status_o), .entry_pulse(entry_pulse), .entry_cause(entry_cause),
  .spsr_o(spsr_o), .next_fetch(next_fetch), .pc_next(pc_next)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swi_req = 0, und_req = 0, fiq_req = 0, status_wr = 0;
  logic [NL-1:0] int_enable = '0, int_flag = '0, int_master = '0;
  logic [31:0] cur_pc = '0, status_wdata = '0;
  logic [31:0] status_o, link_o, spsr_o, next_fetch, pc_next;
  logic entry_pulse;
  logic [1:0] entry_cause;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_status, m_link, m_spsr, m_fetch, m_pc;
  logic m_pulse;
  logic [1:0] m_cause;

  exc_entry_seq #(.IRQ_LINES(NL)) i_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .swi_req(swi_req), .und_req(und_req),
    .fiq_req(fiq_req), .int_enable(int_enable), .int_flag(int_flag),
    .int_master(int_master), .cur_pc(cur_pc), .status_wr(status_wr),
    .status_wdata(status_wdata), .status_o(status_o), .entry_pulse(entry_pulse),
    .entry_cause(entry_cause), .link_o(link_o), .spsr_o(spsr_o),
    .next_fetch(next_fetch), .pc_next(pc_next)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "status", status_o, m_status);
    check(tag, "pulse", {31'd0, entry_pulse}, {31'd0, m_pulse});
    check(tag, "cause", {30'd0, entry_cause}, {30'd0, m_cause});
    check(tag, "link", link_o, m_link);
    check(tag, "saved", spsr_o, m_spsr);
    check(tag, "fetch", next_fetch, m_fetch);
    check(tag, "pc", pc_next, m_pc);
  endtask

  // Model one clock with the currently driven inputs, then compare.
  task automatic step(string tag);
    int sel;
    bit irq_ok;
    sel = -1;
    irq_ok = (m_status[7] == 1'b0) && ((int_enable & int_flag) != 0) && int_master[0];
    if (fiq_req && !m_status[6]) sel = 3;
    else if (irq_ok)             sel = 2;
    else if (und_req)            sel = 1;
    else if (swi_req)            sel = 0;
    m_pulse = (sel >= 0);
    if (sel >= 0) begin
      m_cause = sel[1:0];
      m_spsr  = m_status;
      m_link  = (sel < 2) ? cur_pc - 4 : cur_pc;
      case (sel)
        0: begin m_fetch = 32'h08; m_status[4:0] = 5'h13; end
        1: begin m_fetch = 32'h04; m_status[4:0] = 5'h1B; end
        2: begin m_fetch = 32'h18; m_status[4:0] = 5'h12; end
        default: begin m_fetch = 32'h1C; m_status[4:0] = 5'h11; m_status[6] = 1'b1; end
      endcase
      m_status[7] = 1'b1;
      m_pc = m_fetch + 4;
    end else if (status_wr) begin
      m_status = status_wdata;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    swi_req = 0; und_req = 0; fiq_req = 0; status_wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_status = 32'h5F; m_link = 0; m_spsr = 0; m_fetch = 0; m_pc = 0;
    m_pulse = 0; m_cause = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1");

    // R2 software trap, R11 strobe then hold
    cur_pc = 32'h0000_0100; swi_req = 1; step("R2");
    cur_pc = 32'h0000_0200; step("R11");
    // R3 undefined
    cur_pc = 32'h0000_0300; und_req = 1; step("R3");

    // reopen masks: mode 0x1F, bits 7/6 clear
    status_wr = 1; status_wdata = 32'h0000_001F; step("R12");
    // R7 gating: no match, then master off, then all agree
    int_enable = 16'h00F0; int_flag = 16'h000F; int_master = 16'h0001; step("R7");
    int_flag = 16'h0010; int_master = 16'h0000; step("R7");
    int_master = 16'h0001; cur_pc = 32'h0000_0400; step("R4");
    // interrupt now masked by bit 7
    step("R7");
    int_flag = 16'h0000;

    // R5 fast interrupt, then R8 ignored while masked
    status_wr = 1; status_wdata = 32'hF000_001F; step("R12");
    fiq_req = 1; cur_pc = 32'h0000_0500; step("R5");
    fiq_req = 1; step("R8");

    // R9 priority ladder
    status_wr = 1; status_wdata = 32'h0000_001F; step("R12");
    int_flag = 16'h0010;
    fiq_req = 1; und_req = 1; swi_req = 1; cur_pc = 32'h0000_0600; step("R9");
    status_wr = 1; status_wdata = 32'h0000_001F; step("R12");
    und_req = 1; swi_req = 1; cur_pc = 32'h0000_0700; step("R9");
    status_wr = 1; status_wdata = 32'h0000_009F; step("R12");
    und_req = 1; swi_req = 1; cur_pc = 32'h0000_0800; step("R9");
    int_flag = 16'h0000;

    // R12 write dropped when an entry coincides; R6 upper bits kept
    status_wr = 1; status_wdata = 32'hA000_003F; step("R12");
    status_wr = 1; status_wdata = 32'h1234_5600; swi_req = 1;
    cur_pc = 32'h0000_0004; step("R6");
    step("R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule